// File: doc/BRIEF.md
# Store Queue Burst Writer

A write-only staging buffer between a CPU store path and a burst-capable memory port. The CPU writes 32-bit words, with byte enables, into one of two 32-byte line queues. A line is never fetched from memory first; stores only patch the local copy. When software wants a line in memory, it issues a flush command for that queue. The block then moves the full 32-byte line as one burst of eight incrementing beats.

The two queues work on their own, so one can be refilled while the other drains. A store or flush aimed at a queue that has a drain waiting or running is held back with a stall. The upper address bits of each burst come from a configuration input, and the flush command supplies the rest of the line address.

Top module: `sq_burst_writer`

## Requirements
- R1: After reset `mValid` and `stall` are low, and every byte of both queues holds zero, so a flush right after reset drains eight zero words.
- R2: An accepted store writes byte lane b of `stData` into word `stWordAddr[2:0]` of queue `stWordAddr[3]` (byte-address bits 4:2 and 5) for each set bit b of `stBe`. Bytes whose enable is clear keep their value.
- R3: Stores alone never start a burst. `mValid` stays low until a flush has been accepted, and no read is ever issued.
- R4: When a flush is accepted at a clock edge while the memory port is idle, `mValid` is low after that edge and rises at the next edge.
- R5: A burst is exactly eight beats. Beat k carries word k of the queue at address target + 4·k. `mLast` is high on the eighth beat only.
- R6: A beat completes only at an edge where `mValid` and `mReady` are both high. While `mReady` is low, `mAddr`, `mData` and `mLast` hold their values.
- R7: The burst target is {`cfgUpper`, `flushLineAddr`, 5'b0}, with `cfgUpper` sampled when the flush is accepted. Later changes to `cfgUpper` do not alter that burst.
- R8: `stall` is high, and the command has no effect, while a store or flush targets a queue whose drain is waiting or running. Commands to the other queue are accepted meanwhile. The queue of a flush is `flushLineAddr[0]`.
- R9: Draining does not clear a queue. Flushing a queue with no stores since its last drain sends the previous contents again.
- R10: Each queue's burst contains only data stored to that queue.
- R11: Bursts leave in the order their flushes were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgUpper | input | 6 | Upper target address bits 31:26 |
| stValid | input | 1 | Store request |
| stWordAddr | input | 4 | Store word address: bit 3 queue, bits 2:0 word |
| stData | input | 32 | Store data |
| stBe | input | 4 | Store byte enables |
| flushValid | input | 1 | Flush (drain) command |
| flushLineAddr | input | 21 | Target line index, byte-address bits 25:5; bit 0 selects the queue |
| stall | output | 1 | Command held back this cycle |
| mAddr | output | 32 | Beat byte address |
| mData | output | 32 | Beat data |
| mLast | output | 1 | Final beat of the burst |
| mValid | output | 1 | Beat valid |
| mReady | input | 1 | Memory accepts the beat |

## Verification
The hardest state to reach is the one where the two queues overlap. One queue is part way through a burst that is being slowed by `mReady`, and the other has a flush waiting. In that state, stores and flushes to each queue must be split correctly into stalled and accepted. The bench reaches it by issuing two flushes on consecutive cycles while the memory model drops `mReady` on every other cycle. It then fires stores and a repeat flush at both queues during that window. Once the first burst completes, it switches to a slower ready pattern and stores to the freed queue while the second queue is still draining.

// File: rtl/sqbw_pkg.sv
package sqbw_pkg;

  typedef struct packed {
    logic wrStore;    // commit the store on the store port
    logic capTarget;  // latch the flush target line
  } sqStrobe_t;

  typedef enum logic {
    S_IDLE  = 1'b0,
    S_BURST = 1'b1
  } sqState_e;

endpackage

// File: rtl/sqbw_ctrl.sv
module sqbw_ctrl
  import sqbw_pkg::*;
#(
  parameter int NUM_Q  = 2,
  parameter int WORDS  = 8,
  parameter int QSEL_W = 1,
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stValid,
  input  logic [QSEL_W-1:0] stQ,
  input  logic              flushValid,
  input  logic [QSEL_W-1:0] flushQ,
  input  logic              mReady,
  output logic              stall,
  output logic              mValid,
  output logic              mLast,
  output sqStrobe_t         strb,
  output logic [QSEL_W-1:0] rdQ,
  output logic [BEAT_W-1:0] rdBeat
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(WORDS - 1);

  sqState_e          state;
  logic [NUM_Q-1:0]  pend;
  logic [NUM_Q-1:0]  pendNext;
  logic [NUM_Q-1:0]  busyVec;
  logic [QSEL_W-1:0] activeQ;
  logic [QSEL_W-1:0] pickQ;
  logic              anyPend;
  logic [BEAT_W-1:0] beat;
  logic              accept;

  // a queue is locked while its drain waits or runs
  for (genvar i = 0; i < NUM_Q; i++) begin : g_busy
    assign busyVec[i] = pend[i] | ((state == S_BURST) && (activeQ == QSEL_W'(i)));
  end

  always_comb begin
    pickQ   = '0;
    anyPend = |pend;
    for (int i = NUM_Q - 1; i >= 0; i--) begin
      if (pend[i]) pickQ = QSEL_W'(i);
    end
  end

  assign stall          = (stValid && busyVec[stQ]) || (flushValid && busyVec[flushQ]);
  assign accept         = !stall;
  assign strb.wrStore   = stValid && accept;
  assign strb.capTarget = flushValid && accept;

  always_comb begin
    pendNext = pend;
    if (strb.capTarget) pendNext[flushQ] = 1'b1;
    if ((state == S_IDLE) && anyPend) pendNext[pickQ] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      pend    <= '0;
      activeQ <= '0;
      beat    <= '0;
    end else begin
      pend <= pendNext;
      case (state)
        S_IDLE: begin
          if (anyPend) begin
            state   <= S_BURST;
            activeQ <= pickQ;
            beat    <= '0;
          end
        end
        S_BURST: begin
          if (mReady) begin
            beat <= beat + 1'b1;
            if (beat == LAST_BEAT) state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mValid = (state == S_BURST);
  assign mLast  = mValid && (beat == LAST_BEAT);
  assign rdQ    = activeQ;
  assign rdBeat = beat;

  // R6: a stalled beat keeps its position in the line
  p_hold_beat_r6: assert property (@(posedge clk) disable iff (!rstN)
    mValid && !mReady |=> mValid && $stable(rdBeat) && $stable(rdQ));

  // R5: the burst ends after the last beat is taken
  p_end_after_last_r5: assert property (@(posedge clk) disable iff (!rstN)
    mValid && mReady && mLast |=> !mValid);

  // R8: an accepted flush locks its queue from the next cycle on
  p_flush_locks_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.capTarget |=> busyVec[$past(flushQ)]);

endmodule

// File: rtl/sqbw_datapath.sv
module sqbw_datapath
  import sqbw_pkg::*;
#(
  parameter int NUM_Q   = 2,
  parameter int WORDS   = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int QSEL_W  = 1,
  parameter int BEAT_W  = 3,
  parameter int OFF_W   = 2,
  parameter int LINE_W  = 27
) (
  input  logic              clk,
  input  logic              rstN,
  input  sqStrobe_t         strb,
  input  logic [QSEL_W-1:0] stQ,
  input  logic [BEAT_W-1:0] stWord,
  input  logic [DATA_W-1:0] stData,
  input  logic [DATA_W/8-1:0] stBe,
  input  logic [QSEL_W-1:0] flushQ,
  input  logic [LINE_W-1:0] flushLine,
  input  logic [QSEL_W-1:0] rdQ,
  input  logic [BEAT_W-1:0] rdBeat,
  output logic [ADDR_W-1:0] mAddr,
  output logic [DATA_W-1:0] mData
);

  localparam int BYTES = DATA_W / 8;

  logic [DATA_W-1:0] qWord [NUM_Q];
  logic [LINE_W-1:0] qTgt  [NUM_Q];

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    logic [DATA_W-1:0] words [WORDS];
    logic [LINE_W-1:0] tgt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int w = 0; w < WORDS; w++) words[w] <= '0;
        tgt <= '0;
      end else begin
        if (strb.wrStore && (stQ == QSEL_W'(q))) begin
          for (int b = 0; b < BYTES; b++) begin
            if (stBe[b]) words[stWord][8*b +: 8] <= stData[8*b +: 8];
          end
        end
        if (strb.capTarget && (flushQ == QSEL_W'(q))) tgt <= flushLine;
      end
    end

    assign qWord[q] = words[rdBeat];
    assign qTgt[q]  = tgt;
  end

  assign mData = qWord[rdQ];
  assign mAddr = {qTgt[rdQ], rdBeat, {OFF_W{1'b0}}};

endmodule

// File: rtl/sq_burst_writer.sv
module sq_burst_writer
  import sqbw_pkg::*;
#(
  parameter int NUM_Q  = 2,
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int HI_LSB = 26
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ADDR_W-HI_LSB-1:0]       cfgUpper,
  input  logic                           stValid,
  input  logic [$clog2(NUM_Q)+$clog2(WORDS)-1:0] stWordAddr,
  input  logic [DATA_W-1:0]              stData,
  input  logic [DATA_W/8-1:0]            stBe,
  input  logic                           flushValid,
  input  logic [HI_LSB-$clog2(WORDS*DATA_W/8)-1:0] flushLineAddr,
  output logic                           stall,
  output logic [ADDR_W-1:0]              mAddr,
  output logic [DATA_W-1:0]              mData,
  output logic                           mLast,
  output logic                           mValid,
  input  logic                           mReady
);

  localparam int QSEL_W    = $clog2(NUM_Q);
  localparam int BEAT_W    = $clog2(WORDS);
  localparam int BYTES     = DATA_W / 8;
  localparam int OFF_W     = $clog2(BYTES);
  localparam int LINE_BITS = BEAT_W + OFF_W;
  localparam int LINE_W    = ADDR_W - LINE_BITS;

  sqStrobe_t         strb;
  logic [QSEL_W-1:0] stQ;
  logic [BEAT_W-1:0] stWord;
  logic [QSEL_W-1:0] flushQ;
  logic [LINE_W-1:0] flushLine;
  logic [QSEL_W-1:0] rdQ;
  logic [BEAT_W-1:0] rdBeat;

  assign stQ       = stWordAddr[BEAT_W +: QSEL_W];
  assign stWord    = stWordAddr[BEAT_W-1:0];
  assign flushQ    = flushLineAddr[QSEL_W-1:0];
  assign flushLine = {cfgUpper, flushLineAddr};

  sqbw_ctrl #(
    .NUM_Q (NUM_Q),
    .WORDS (WORDS),
    .QSEL_W(QSEL_W),
    .BEAT_W(BEAT_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .stValid   (stValid),
    .stQ       (stQ),
    .flushValid(flushValid),
    .flushQ    (flushQ),
    .mReady    (mReady),
    .stall     (stall),
    .mValid    (mValid),
    .mLast     (mLast),
    .strb      (strb),
    .rdQ       (rdQ),
    .rdBeat    (rdBeat)
  );

  sqbw_datapath #(
    .NUM_Q (NUM_Q),
    .WORDS (WORDS),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .QSEL_W(QSEL_W),
    .BEAT_W(BEAT_W),
    .OFF_W (OFF_W),
    .LINE_W(LINE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .stQ      (stQ),
    .stWord   (stWord),
    .stData   (stData),
    .stBe     (stBe),
    .flushQ   (flushQ),
    .flushLine(flushLine),
    .rdQ      (rdQ),
    .rdBeat   (rdBeat),
    .mAddr    (mAddr),
    .mData    (mData)
  );

  // R5: consecutive beats step by one word
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    mValid && mReady && !mLast |=> mAddr == $past(mAddr) + ADDR_W'(BYTES));

  // R6: outputs hold while the memory side is not ready
  p_hold_out_r6: assert property (@(posedge clk) disable iff (!rstN)
    mValid && !mReady |=> $stable(mAddr) && $stable(mData) && $stable(mLast));

endmodule

// File: tb/sq_burst_writer_tb.sv
module sq_burst_writer_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic [5:0]  cfgUpper;
  logic        stValid;
  logic [3:0]  stWordAddr;
  logic [31:0] stData;
  logic [3:0]  stBe;
  logic        flushValid;
  logic [20:0] flushLineAddr;
  logic        stall;
  logic [31:0] mAddr;
  logic [31:0] mData;
  logic        mLast;
  logic        mValid;
  logic        mReady;

  sq_burst_writer u_dut (
    .clk(clk), .rstN(rstN), .cfgUpper(cfgUpper), .stValid(stValid),
    .stWordAddr(stWordAddr), .stData(stData), .stBe(stBe),
    .flushValid(flushValid), .flushLineAddr(flushLineAddr), .stall(stall),
    .mAddr(mAddr), .mData(mData), .mLast(mLast), .mValid(mValid), .mReady(mReady)
  );

  always #2 clk = ~clk;

  int total = 0;
  int fails = 0;
  logic [31:0] model [2][8];
  logic [31:0] expAddr [16];
  logic [31:0] expData [16][8];
  int head = 0;
  int tail = 0;
  int readyMode = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  // memory-side model and beat checker
  initial begin : mon
    int cyc = 0;
    int beatIdx = 0;
    bit holdPrev = 0;
    logic [31:0] pA, pD;
    logic pL;
    mReady = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      case (readyMode)
        0: mReady = 1'b1;
        1: mReady = cyc[0];
        default: mReady = (cyc % 3 == 0);
      endcase
      if (holdPrev) begin
        chk(mValid && mAddr == pA && mData == pD && mLast == pL, "R6",
            "beat changed while not ready", mData, pD);
      end
      if (mValid) begin
        if (head == tail) begin
          chk(0, "R3", "beat without accepted flush", mAddr, 32'h0);
        end else if (mReady) begin
          chk(mAddr == expAddr[head % 16] + 32'(4 * beatIdx), "R5/R7/R11", "beat address",
              mAddr, expAddr[head % 16] + 32'(4 * beatIdx));
          chk(mData == expData[head % 16][beatIdx], "R5/R9/R10", "beat data",
              mData, expData[head % 16][beatIdx]);
          chk(mLast == (beatIdx == 7), "R5", "last flag", 32'(mLast), 32'(beatIdx == 7));
          beatIdx++;
          if (beatIdx == 8) begin
            beatIdx = 0;
            head++;
          end
        end
        holdPrev = !mReady;
        pA = mAddr; pD = mData; pL = mLast;
      end else begin
        holdPrev = 0;
      end
    end
  end

  task automatic doStore(input int q, input int w, input logic [31:0] d,
                         input logic [3:0] be, input bit expStall);
    @(negedge clk);
    stValid = 1'b1; flushValid = 1'b0;
    stWordAddr = {1'(q), 3'(w)}; stData = d; stBe = be;
    #1;
    chk(stall == expStall, "R8", "store stall", 32'(stall), 32'(expStall));
    if (!expStall) begin
      for (int b = 0; b < 4; b++) if (be[b]) model[q][w][8*b +: 8] = d[8*b +: 8];
    end
    @(posedge clk);
  endtask

  task automatic doFlush(input logic [20:0] line, input logic [5:0] cfg, input bit expStall);
    @(negedge clk);
    stValid = 1'b0; flushValid = 1'b1;
    flushLineAddr = line; cfgUpper = cfg;
    #1;
    chk(stall == expStall, "R8", "flush stall", 32'(stall), 32'(expStall));
    if (!expStall) begin
      expAddr[tail % 16] = {cfg, line, 5'b0};
      for (int w = 0; w < 8; w++) expData[tail % 16][w] = model[line[0]][w];
      tail++;
    end
    @(posedge clk);
  endtask

  task automatic cpuIdle();
    @(negedge clk);
    stValid = 1'b0; flushValid = 1'b0;
  endtask

  task automatic waitHead(input int n);
    while (head < n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "R5", "watchdog expired", 32'(head), 32'(tail));
      summary();
      $finish;
    end
  end

  initial begin : main
    rstN = 1'b0; stValid = 0; flushValid = 0; stWordAddr = 0; stData = 0;
    stBe = 0; flushLineAddr = 0; cfgUpper = 0;
    for (int q = 0; q < 2; q++) for (int w = 0; w < 8; w++) model[q][w] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(mValid == 1'b0, "R1", "mValid after reset", 32'(mValid), 32'h0);
    chk(stall == 1'b0, "R1", "stall after reset", 32'(stall), 32'h0);

    // R1, R4, R7: drain of a never-written queue, latency check
    doFlush(21'h0ABCDE, 6'h2A, 0);
    cpuIdle();
    chk(mValid == 1'b0, "R4", "mValid one edge after flush", 32'(mValid), 32'h0);
    @(negedge clk);
    chk(mValid == 1'b1, "R4", "mValid two edges after flush", 32'(mValid), 32'h1);
    waitHead(tail);

    // R2, R3: byte-enable sweep over every word of both queues
    for (int q = 0; q < 2; q++)
      for (int w = 0; w < 8; w++)
        for (int be = 1; be < 16; be++)
          doStore(q, w, {8'(q * 16 + w), 8'(be), 8'(w * 3 + 1), 8'h5A ^ 8'(be * 7)}, 4'(be), 0);
    cpuIdle();
    repeat (3) @(negedge clk);
    chk(mValid == 1'b0 && head == tail, "R3", "no burst from stores", 32'(mValid), 32'h0);

    // R8, R10, R11: overlap of the two queues under a slow memory
    readyMode = 1;
    doFlush(21'h001234, 6'h15, 0);
    doFlush(21'h000777, 6'h16, 0);
    doStore(0, 2, 32'hDEADBEEF, 4'hF, 1);
    doStore(1, 5, 32'hCAFEF00D, 4'hF, 1);
    doFlush(21'h000010, 6'h01, 1);
    cpuIdle();
    waitHead(head + 1);
    readyMode = 2;
    doStore(0, 3, 32'h11223344, 4'b0101, 0);
    cpuIdle();
    waitHead(tail);

    // R9: clean queue drains stale data again; R2 partial update on q0
    readyMode = 0;
    doFlush(21'h1FFFF1, 6'h07, 0);
    doFlush(21'h000100, 6'h08, 0);
    cpuIdle();
    waitHead(tail);

    // R7: cfgUpper sampled at acceptance, changed during the burst
    doFlush(21'h0F0F0E, 6'h3F, 0);
    @(negedge clk);
    flushValid = 1'b0;
    cfgUpper = 6'h00;
    waitHead(tail);
    repeat (3) @(negedge clk);
    chk(head == tail && mValid == 1'b0, "R11", "all bursts drained", 32'(head), 32'(tail));

    done = 1;
    summary();
    $finish;
  end

endmodule